// File: doc/BRIEF.md
# Dual-Rail Handshaked Pipeline Register

This block is one registration stage of a delay-insensitive, dual-rail pipeline. It is modelled with a simulation clock so that it stays synthesizable. Each bit of the word travels on two rails. Rail 0 high means the bit carries a zero, rail 1 high means it carries a one, and both rails low means the bit is empty (NULL). The stage accepts a data wavefront only when the following stage asks for data. It lets go of that wavefront only when the following stage asks for NULL. As a result, every pair of data wavefronts passing through it is separated by an empty one.

Each rail of the register is a two-input hysteresis element over the incoming rail and the request from the next stage. The rail turns on only when both of these are high, and it turns off only when both are low. In every other case it keeps its value.

A completion detector looks at the register outputs and drives the acknowledge back to the previous stage. That acknowledge goes low once every bit holds data, and it goes high once every bit is empty. While the word is partly filled, the acknowledge keeps its last value. An input bit with both rails high is illegal. Such a bit is not loaded into the register, and it raises an error flag.

Top module: `drail_reg_stage`

## Requirements
- R1: While reset is asserted and after it is released, every register bit is NULL (`q_r0` = `q_r1` = 0), `ack_out` = 1 and `bad_code` = 0.
- R2: Bit i holds DATA0 when `q_r0[i]`=1 and `q_r1[i]`=0, holds DATA1 when `q_r1[i]`=1 and `q_r0[i]`=0, and holds NULL when both are 0. The outputs show the value captured at the last rising clock edge.
- R3: A register rail becomes 1 only at an edge where its input rail and `req_in` are both 1. When `req_in` is 0, a DATA input leaves a NULL register unchanged.
- R4: A register rail becomes 0 only at an edge where its input rail and `req_in` are both 0. When `req_in` is 1, a NULL input leaves a DATA register unchanged.
- R5: In the same cycle that every register bit holds DATA, `ack_out` is 0.
- R6: In the same cycle that every register bit is NULL, `ack_out` is 1.
- R7: While the register holds a mix of DATA and NULL bits, `ack_out` keeps the value it had in the previous cycle.
- R8: An input bit with both rails at 1 leaves that register bit unchanged at the edge, and `bad_code` is 1 in the following cycle.
- R9: `bad_code` is 0 in the cycle after an edge at which no input bit had both rails at 1.
- R10: No register bit ever has both output rails at 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Simulation clock |
| rst_n | input | 1 | Active-low synchronous reset |
| d_r0 | input | WIDTH | Incoming rail 0 (DATA0) of each bit |
| d_r1 | input | WIDTH | Incoming rail 1 (DATA1) of each bit |
| req_in | input | 1 | Request from the next stage: 1 asks for DATA, 0 asks for NULL |
| q_r0 | output | WIDTH | Registered rail 0 of each bit |
| q_r1 | output | WIDTH | Registered rail 1 of each bit |
| ack_out | output | 1 | Completion acknowledge to the previous stage |
| bad_code | output | 1 | An input bit had both rails high at the last edge |

## Verification
The illegal-code check and the completion update can fall into the same cycle. This is the case when one input bit carries both rails while the other bits complete a wavefront. The bench provokes this both while filling and while draining. In one case an illegal bit arrives with data on the other bits while a request for data is pending. In the other it arrives with empty rails on the other bits while a request for NULL is pending. In both cases it checks three things in the same cycle: the flag is raised, the illegal bit keeps its old value, and the acknowledge holds because the word is left partly complete. The next vector then repairs that bit, and the bench confirms that the flag drops as the acknowledge finally toggles.

// File: rtl/drail_pkg.sv
package drail_pkg;

   // Encoding of one dual-rail bit as {rail1, rail0}
   typedef enum logic [1:0] {
      DR_NULL  = 2'b00,
      DR_ZERO  = 2'b01,
      DR_ONE   = 2'b10,
      DR_ILLEG = 2'b11
   } dr_code_e;

   function automatic logic dr_is_illegal(input logic r0, input logic r1);
      return r0 & r1;
   endfunction

endpackage

// File: rtl/drail_hyst_cell.sv
// Two-input hysteresis element (2-of-2 threshold with memory), clocked model.
module drail_hyst_cell (
   input  logic clk,
   input  logic rst_n,
   input  logic en,
   input  logic rail_in,
   input  logic req,
   output logic q
);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         q <= 1'b0;
      end else if (en) begin
         if (rail_in && req)
            q <= 1'b1;
         else if (!rail_in && !req)
            q <= 1'b0;
      end
   end

   assert_set_cond_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(q) |-> $past(rail_in && req));

   assert_clr_cond_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(q) |-> $past(!rail_in && !req));

endmodule

// File: rtl/drail_completion.sv
// Completion detection over a dual-rail word.
module drail_completion #(
   parameter int WIDTH = 8
) (
   input  logic [WIDTH-1:0] r0,
   input  logic [WIDTH-1:0] r1,
   output logic             all_data,
   output logic             all_null
);

   logic [WIDTH-1:0] bit_done;

   for (genvar i = 0; i < WIDTH; i++) begin : g_bit
      assign bit_done[i] = r0[i] | r1[i];
   end

   assign all_data = &bit_done;
   assign all_null = ~|bit_done;

endmodule

// File: rtl/drail_reg_stage.sv
module drail_reg_stage
   import drail_pkg::*;
#(
   parameter int WIDTH = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d_r0,
   input  logic [WIDTH-1:0] d_r1,
   input  logic             req_in,
   output logic [WIDTH-1:0] q_r0,
   output logic [WIDTH-1:0] q_r1,
   output logic             ack_out,
   output logic             bad_code
);

   if (WIDTH < 1) begin : g_bad_width
      $error("drail_reg_stage: WIDTH must be at least 1");
   end

   logic [WIDTH-1:0] bit_legal;
   logic             any_illegal;
   logic             cd_all_data;
   logic             cd_all_null;
   logic             ack_q;
   logic             bad_q;

   for (genvar i = 0; i < WIDTH; i++) begin : g_lane
      assign bit_legal[i] = !dr_is_illegal(d_r0[i], d_r1[i]);

      drail_hyst_cell u_rail0 (
         .clk     (clk),
         .rst_n   (rst_n),
         .en      (bit_legal[i]),
         .rail_in (d_r0[i]),
         .req     (req_in),
         .q       (q_r0[i])
      );

      drail_hyst_cell u_rail1 (
         .clk     (clk),
         .rst_n   (rst_n),
         .en      (bit_legal[i]),
         .rail_in (d_r1[i]),
         .req     (req_in),
         .q       (q_r1[i])
      );
   end

   assign any_illegal = ~&bit_legal;

   drail_completion #(.WIDTH(WIDTH)) u_cd (
      .r0       (q_r0),
      .r1       (q_r1),
      .all_data (cd_all_data),
      .all_null (cd_all_null)
   );

   // Acknowledge: low on full DATA, high on full NULL, held otherwise
   always_comb begin
      if (cd_all_data)
         ack_out = 1'b0;
      else if (cd_all_null)
         ack_out = 1'b1;
      else
         ack_out = ack_q;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ack_q <= 1'b1;
         bad_q <= 1'b0;
      end else begin
         ack_q <= ack_out;
         bad_q <= any_illegal;
      end
   end

   assign bad_code = bad_q;

   assert_no_double_rail_R10: assert property (@(posedge clk) disable iff (!rst_n)
      ~|(q_r0 & q_r1));

   assert_ack_fall_full_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(ack_out) |-> &(q_r0 | q_r1));

   assert_ack_rise_empty_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ack_out) |-> ~|(q_r0 | q_r1));

   assert_flag_source_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(bad_code) |-> $past(|(d_r0 & d_r1)));

   assert_illegal_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      ((d_r0 & d_r1) != '0) |=> (((q_r0 ^ $past(q_r0)) & $past(d_r0 & d_r1)) == '0));

endmodule

// File: tb/tb_drail_reg_stage.sv
module tb_drail_reg_stage;

   localparam int W    = 4;
   localparam int NVEC = 12;

   logic         clk = 1'b0;
   logic         rst_n;
   logic [W-1:0] d_r0, d_r1;
   logic         req_in;
   logic [W-1:0] q_r0, q_r1;
   logic         ack_out, bad_code;

   int checks = 0;
   int fails  = 0;

   always #5 clk = ~clk;

   drail_reg_stage #(.WIDTH(W)) dut (
      .clk(clk), .rst_n(rst_n), .d_r0(d_r0), .d_r1(d_r1), .req_in(req_in),
      .q_r0(q_r0), .q_r1(q_r1), .ack_out(ack_out), .bad_code(bad_code)
   );

   // {in_r0, in_r1, req, exp_r0, exp_r1, exp_ack, exp_bad}
   localparam logic [18:0] VEC [NVEC] = '{
      {4'b1010, 4'b0101, 1'b0, 4'b0000, 4'b0000, 1'b1, 1'b0}, // R3 no entry without request
      {4'b1010, 4'b0101, 1'b1, 4'b1010, 4'b0101, 1'b0, 1'b0}, // R2 R5 load data
      {4'b0000, 4'b0000, 1'b1, 4'b1010, 4'b0101, 1'b0, 1'b0}, // R4 hold data
      {4'b0000, 4'b0000, 1'b0, 4'b0000, 4'b0000, 1'b1, 1'b0}, // R6 drain to NULL
      {4'b0011, 4'b0000, 1'b1, 4'b0011, 4'b0000, 1'b1, 1'b0}, // R7 partial fill
      {4'b0011, 4'b1100, 1'b1, 4'b0011, 4'b1100, 1'b0, 1'b0}, // R5 complete fill
      {4'b0000, 4'b1100, 1'b0, 4'b0000, 4'b1100, 1'b0, 1'b0}, // R7 partial drain
      {4'b0000, 4'b0000, 1'b0, 4'b0000, 4'b0000, 1'b1, 1'b0}, // R6 complete drain
      {4'b0011, 4'b1101, 1'b1, 4'b0010, 4'b1100, 1'b1, 1'b1}, // R8 illegal while filling
      {4'b0011, 4'b1100, 1'b1, 4'b0011, 4'b1100, 1'b0, 1'b0}, // R9 repaired
      {4'b0001, 4'b0001, 1'b0, 4'b0001, 4'b0000, 1'b0, 1'b1}, // R8 illegal while draining
      {4'b0000, 4'b0000, 1'b0, 4'b0000, 4'b0000, 1'b1, 1'b0}  // R9 repaired
   };

   function automatic string vec_tag(input int k);
      case (k)
         0: return "R3";
         1: return "R2/R5";
         2: return "R4";
         3: return "R6";
         4: return "R7";
         5: return "R5";
         6: return "R7";
         7: return "R6";
         8: return "R8";
         9: return "R9";
         10: return "R8";
         default: return "R9";
      endcase
   endfunction

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic apply(input logic [W-1:0] a0, input logic [W-1:0] a1, input logic rq);
      @(negedge clk);
      d_r0 = a0; d_r1 = a1; req_in = rq;
      @(posedge clk);
      #1;
   endtask

   initial begin
      #(200000 * 10);
      fails++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", checks, fails);
      $finish;
   end

   initial begin
      rst_n = 1'b0; d_r0 = '0; d_r1 = '0; req_in = 1'b0;
      repeat (3) @(posedge clk);
      #1;
      chk("R1 q_r0", 32'(q_r0), 32'(0));
      chk("R1 q_r1", 32'(q_r1), 32'(0));
      chk("R1 ack", 32'(ack_out), 32'(1));
      chk("R1 bad", 32'(bad_code), 32'(0));
      @(negedge clk);
      rst_n = 1'b1;

      for (int k = 0; k < NVEC; k++) begin
         logic [18:0] v;
         v = VEC[k];
         apply(v[18:15], v[14:11], v[10]);
         chk({vec_tag(k), " q_r0"}, 32'(q_r0), 32'(v[9:6]));
         chk({vec_tag(k), " q_r1"}, 32'(q_r1), 32'(v[5:2]));
         chk({vec_tag(k), " ack"}, 32'(ack_out), 32'(v[1]));
         chk({vec_tag(k), " bad"}, 32'(bad_code), 32'(v[0]));
         chk("R10 double rail", 32'(q_r0 & q_r1), 32'(0));
      end

      // R3: data with request low must not enter a NULL register even repeatedly
      apply(4'b1111, 4'b0000, 1'b0);
      apply(4'b1111, 4'b0000, 1'b0);
      chk("R3 held null", 32'(q_r0), 32'(0));
      chk("R6 ack high", 32'(ack_out), 32'(1));

      // R8 all bits illegal: register untouched, ack held
      apply(4'b1111, 4'b1111, 1'b1);
      chk("R8 all illegal q_r0", 32'(q_r0), 32'(0));
      chk("R8 all illegal q_r1", 32'(q_r1), 32'(0));
      chk("R8 all illegal bad", 32'(bad_code), 32'(1));
      chk("R7 ack kept", 32'(ack_out), 32'(1));

      // R1: reset while data is held
      apply(4'b0110, 4'b1001, 1'b1);
      chk("R5 full before reset", 32'(ack_out), 32'(0));
      @(negedge clk);
      rst_n = 1'b0;
      @(posedge clk);
      #1;
      chk("R1 reset q_r0", 32'(q_r0), 32'(0));
      chk("R1 reset q_r1", 32'(q_r1), 32'(0));
      chk("R1 reset ack", 32'(ack_out), 32'(1));
      chk("R1 reset bad", 32'(bad_code), 32'(0));

      $display("  test done: total=%0d bad=%0d", checks, fails);
      $finish;
   end

endmodule